// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two IEEE 754 binary32 operands in a four-stage pipeline. The first stage decodes both operands, classifies special values, orders them by magnitude and shifts the smaller significand right to the larger exponent. Shifted-out bits are kept as guard, round and sticky. The second stage adds or subtracts the aligned significands. The third stage normalizes: it shifts right on a carry and left on cancellation, and it detects exponent overflow and results that fall into the subnormal range. The fourth stage rounds to nearest, ties to even, and packs the result.

A new operation can be issued on every clock. Each result leaves with an output valid exactly four cycles after its input valid, and results come out in issue order. Signed zeros, subnormal inputs and outputs, infinities and NaNs are all handled in the datapath. No exception flags are produced.

Top module: `fp_add_pipe`

## Requirements
- R1: Operands and result use bit 31 as sign, bits 30:23 as the exponent biased by 127 and bits 22:0 as the fraction; finite normal operands give the correctly rounded sum (1.0 + 2.0 = 3.0).
- R2: `op_i` = 0 computes a + b and `op_i` = 1 computes a − b, by inverting the sign of b.
- R3: The operand with the smaller exponent is shifted right by the exponent difference; an operand too small to reach the guard bit only affects the sticky bit (1.0 + smallest subnormal = 1.0).
- R4: Cancellation is normalized by a left shift with the exponent reduced (0.5 + −0.4375 = 0.0625, that is 0x3F000000 + 0xBEE00000 = 0x3D800000).
- R5: Rounding is to nearest with ties to even, using guard, round and sticky bits (0x3F800000 + 0x33800000 = 0x3F800000, 0x3F800001 + 0x33800000 = 0x3F800002, 0x3F800000 + 0x33800001 = 0x3F800001).
- R6: A rounding carry out of the significand renormalizes the result and increments its exponent (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R7: An exponent field of 0 means a subnormal with hidden bit 0; subnormal sums are exact and may carry into the normal range (0x00400000 + 0x00400000 = 0x00800000).
- R8: Exponent overflow gives an infinity with the sign of the result (exponent 0xFF, fraction 0).
- R9: An exactly zero sum of operands with different effective signs is +0; the sum of two zeros with the same effective sign keeps that sign.
- R10: Infinity plus a finite value returns that infinity; two infinities with the same effective sign return that infinity.
- R11: A NaN input, or two infinities with opposite effective signs, gives the quiet NaN 0x7FC00000.
- R12: `valid_o` is asserted exactly four cycles after `valid_i`. One operation is accepted per cycle, and results come out in issue order.
- R13: While `rst_ni` is low, `valid_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 1 | 0 = add, 1 = subtract |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result valid, four cycles after issue |
| result_o | output | 32 | Rounded result |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. At these widths every vector can be written as a plain binary32 hex word. Both ends of the exponent range are reached directly: fields 0xFE (largest finite) and 0x00 (subnormal). Half-ulp and one-ulp operands land exactly on the guard bit, which brings ties, odd-LSB ties and rounding carries into the significand within reach. A back-to-back burst exercises the cycle-accurate latency and in-order delivery.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
  // Class of the result, decided at unpack and carried down the pipe
  typedef enum logic [1:0] {
    CLS_NUM = 2'd0,
    CLS_INF = 2'd1,
    CLS_NAN = 2'd2
  } fpa_cls_e;

  localparam int unsigned GRS_W = 3;  // guard, round, sticky
endpackage

// File: rtl/fpa_align.sv
`timescale 1ns/1ps
module fpa_align #(
  parameter int unsigned EW = 8,
  parameter int unsigned FW = 23,
  localparam int unsigned W  = 1 + EW + FW,
  localparam int unsigned AW = FW + 1 + fpa_pkg::GRS_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 op_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic                 valid_o,
  output fpa_pkg::fpa_cls_e    cls_o,
  output logic                 sign_o,
  output logic                 sub_o,
  output logic [EW-1:0]        exp_o,
  output logic [AW-1:0]        big_o,
  output logic [AW-1:0]        small_o
);
  import fpa_pkg::*;
  localparam logic [EW-1:0] EMAX = '1;

  logic          sa, sb, sb_eff, swap;
  logic [EW-1:0] ea, eb, eg, es, xg, xs, diff;
  logic [FW-1:0] fa, fb, fg, fs;
  logic          a_nan, b_nan, a_inf, b_inf;
  logic [AW-1:0] ext_s, sh_s, al_s;
  logic          sticky;
  fpa_cls_e      cls_n;
  logic          sign_n;

  assign {sa, ea, fa} = a_i;
  assign {sb, eb, fb} = b_i;
  assign sb_eff = sb ^ op_i;

  assign a_nan = (ea == EMAX) && (fa != '0);
  assign b_nan = (eb == EMAX) && (fb != '0);
  assign a_inf = (ea == EMAX) && (fa == '0);
  assign b_inf = (eb == EMAX) && (fb == '0);

  // order by magnitude so the subtraction never goes negative
  assign swap = {eb, fb} > {ea, fa};
  assign eg   = swap ? eb : ea;
  assign es   = swap ? ea : eb;
  assign fg   = swap ? fb : fa;
  assign fs   = swap ? fa : fb;
  assign xg   = (eg == '0) ? EW'(1) : eg;
  assign xs   = (es == '0) ? EW'(1) : es;
  assign diff = xg - xs;

  assign ext_s = {(es != '0), fs, {GRS_W{1'b0}}};

  always_comb begin
    if (int'(diff) >= AW) begin
      sh_s   = '0;
      sticky = |ext_s;
    end else begin
      sh_s   = ext_s >> diff;
      sticky = (sh_s << diff) != ext_s;
    end
    al_s = {sh_s[AW-1:1], sh_s[0] | sticky};
  end

  always_comb begin
    cls_n  = CLS_NUM;
    sign_n = swap ? sb_eff : sa;
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb_eff))) begin
      cls_n = CLS_NAN;
    end else if (a_inf || b_inf) begin
      cls_n  = CLS_INF;
      sign_n = a_inf ? sa : sb_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_NUM;
      sign_o  <= 1'b0;
      sub_o   <= 1'b0;
      exp_o   <= '0;
      big_o   <= '0;
      small_o <= '0;
    end else begin
      valid_o <= valid_i;
      cls_o   <= cls_n;
      sign_o  <= sign_n;
      sub_o   <= sa ^ sb_eff;
      exp_o   <= xg;
      big_o   <= {(eg != '0), fg, {GRS_W{1'b0}}};
      small_o <= al_s;
    end
  end
endmodule

// File: rtl/fpa_addsub.sv
`timescale 1ns/1ps
module fpa_addsub #(
  parameter int unsigned EW = 8,
  parameter int unsigned FW = 23,
  localparam int unsigned AW = FW + 1 + fpa_pkg::GRS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  fpa_pkg::fpa_cls_e cls_i,
  input  logic              sign_i,
  input  logic              sub_i,
  input  logic [EW-1:0]     exp_i,
  input  logic [AW-1:0]     big_i,
  input  logic [AW-1:0]     small_i,
  output logic              valid_o,
  output fpa_pkg::fpa_cls_e cls_o,
  output logic              sign_o,
  output logic              sub_o,
  output logic [EW-1:0]     exp_o,
  output logic [AW:0]       sum_o
);
  import fpa_pkg::*;
  logic [AW:0] sum_n;

  assign sum_n = sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                       : ({1'b0, big_i} + {1'b0, small_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_NUM;
      sign_o  <= 1'b0;
      sub_o   <= 1'b0;
      exp_o   <= '0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      cls_o   <= cls_i;
      sign_o  <= sign_i;
      sub_o   <= sub_i;
      exp_o   <= exp_i;
      sum_o   <= sum_n;
    end
  end
endmodule

// File: rtl/fpa_norm.sv
`timescale 1ns/1ps
module fpa_norm #(
  parameter int unsigned EW = 8,
  parameter int unsigned FW = 23,
  localparam int unsigned AW = FW + 1 + fpa_pkg::GRS_W,
  localparam int unsigned XW = EW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  fpa_pkg::fpa_cls_e cls_i,
  input  logic              sign_i,
  input  logic              sub_i,
  input  logic [EW-1:0]     exp_i,
  input  logic [AW:0]       sum_i,
  output logic              valid_o,
  output fpa_pkg::fpa_cls_e cls_o,
  output logic              sign_o,
  output logic [EW-1:0]     exp_o,
  output logic [AW-2:0]     man_o,
  output logic              ovf_o
);
  import fpa_pkg::*;
  localparam logic [XW-1:0] EMAX_X = XW'({EW{1'b1}});

  int            lead;
  logic [XW-1:0] exp_w, lz_w, sh_w, e_n;
  logic [AW-1:0] man_n;
  logic          sign_n;

  always_comb begin
    lead = 0;
    for (int i = 0; i < int'(AW); i++) if (sum_i[i]) lead = i;
    lz_w   = XW'(int'(AW) - 1 - lead);
    exp_w  = {2'b00, exp_i};
    sign_n = sign_i;
    sh_w   = '0;
    man_n  = '0;
    e_n    = '0;
    if (sum_i[AW]) begin
      man_n = {sum_i[AW:2], |sum_i[1:0]};
      e_n   = exp_w + XW'(1);
    end else if (sum_i == '0) begin
      if (sub_i && cls_i == CLS_NUM) sign_n = 1'b0;  // exact cancel is +0
    end else begin
      // left shift stops at the minimum exponent: subnormal result
      sh_w  = (lz_w < exp_w) ? lz_w : exp_w - XW'(1);
      man_n = sum_i[AW-1:0] << sh_w;
      e_n   = man_n[AW-1] ? exp_w - sh_w : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_NUM;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      man_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      cls_o   <= cls_i;
      sign_o  <= sign_n;
      exp_o   <= e_n[EW-1:0];
      man_o   <= man_n[AW-2:0];
      ovf_o   <= e_n >= EMAX_X;
    end
  end
endmodule

// File: rtl/fpa_round.sv
`timescale 1ns/1ps
module fpa_round #(
  parameter int unsigned EW = 8,
  parameter int unsigned FW = 23,
  localparam int unsigned W  = 1 + EW + FW,
  localparam int unsigned AW = FW + 1 + fpa_pkg::GRS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  fpa_pkg::fpa_cls_e cls_i,
  input  logic              sign_i,
  input  logic [EW-1:0]     exp_i,
  input  logic [AW-2:0]     man_i,
  input  logic              ovf_i,
  output logic              valid_o,
  output logic [W-1:0]      result_o
);
  import fpa_pkg::*;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic             up;
  logic [EW+FW-1:0] packed_r;
  logic [W-1:0]     res_n;

  assign up = man_i[2] & (man_i[1] | man_i[0] | man_i[3]);
  // carry out of the fraction ripples into the exponent: renormalizes,
  // lifts subnormals to normal, and reaches infinity on overflow
  assign packed_r = {exp_i, man_i[AW-2:3]} + {{(EW+FW-1){1'b0}}, up};

  always_comb begin
    unique case (cls_i)
      CLS_NAN: res_n = QNAN;
      CLS_INF: res_n = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
      default: res_n = ovf_i ? {sign_i, {EW{1'b1}}, {FW{1'b0}}}
                             : {sign_i, packed_r};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i;
      result_o <= res_n;
    end
  end
endmodule

// File: rtl/fp_add_pipe.sv
`timescale 1ns/1ps
module fp_add_pipe #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W  = 1 + EXP_W + FRAC_W,
  localparam int unsigned AW = FRAC_W + 1 + fpa_pkg::GRS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o
);
  import fpa_pkg::*;

  logic             v1, s1, sub1;
  fpa_cls_e         c1;
  logic [EXP_W-1:0] e1;
  logic [AW-1:0]    big1, small1;

  logic             v2, s2, sub2;
  fpa_cls_e         c2;
  logic [EXP_W-1:0] e2;
  logic [AW:0]      sum2;

  logic             v3, s3, ovf3;
  fpa_cls_e         c3;
  logic [EXP_W-1:0] e3;
  logic [AW-2:0]    m3;

  fpa_align #(.EW(EXP_W), .FW(FRAC_W)) u_align (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i,
    .valid_o(v1), .cls_o(c1), .sign_o(s1), .sub_o(sub1),
    .exp_o(e1), .big_o(big1), .small_o(small1)
  );

  fpa_addsub #(.EW(EXP_W), .FW(FRAC_W)) u_addsub (
    .clk_i, .rst_ni, .valid_i(v1), .cls_i(c1), .sign_i(s1), .sub_i(sub1),
    .exp_i(e1), .big_i(big1), .small_i(small1),
    .valid_o(v2), .cls_o(c2), .sign_o(s2), .sub_o(sub2),
    .exp_o(e2), .sum_o(sum2)
  );

  fpa_norm #(.EW(EXP_W), .FW(FRAC_W)) u_norm (
    .clk_i, .rst_ni, .valid_i(v2), .cls_i(c2), .sign_i(s2), .sub_i(sub2),
    .exp_i(e2), .sum_i(sum2),
    .valid_o(v3), .cls_o(c3), .sign_o(s3), .exp_o(e3), .man_o(m3), .ovf_o(ovf3)
  );

  fpa_round #(.EW(EXP_W), .FW(FRAC_W)) u_round (
    .clk_i, .rst_ni, .valid_i(v3), .cls_i(c3), .sign_i(s3),
    .exp_i(e3), .man_i(m3), .ovf_i(ovf3),
    .valid_o, .result_o
  );
endmodule

// File: rtl/fp_add_pipe_chk.sv
`timescale 1ns/1ps
module fp_add_pipe_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] result_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic top_exp(input logic [W-1:0] x);
    return x[W-2:FRAC_W] == '1;
  endfunction
  function automatic logic is_nan(input logic [W-1:0] x);
    return top_exp(x) && (x[FRAC_W-1:0] != '0);
  endfunction
  function automatic logic is_inf(input logic [W-1:0] x);
    return top_exp(x) && (x[FRAC_W-1:0] == '0);
  endfunction

  assert_latency_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 4));

  assert_nan_in_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && (is_nan(a_i) || is_nan(b_i)), 4)) |-> result_o == QNAN);

  assert_quiet_out_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && is_nan(result_o)) |-> result_o == QNAN);

  assert_inf_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && is_inf(a_i) && !top_exp(b_i), 4))
      |-> result_o == $past(a_i, 4));

  assert_self_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && op_i && (a_i == b_i) && !top_exp(a_i), 4))
      |-> result_o == '0);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R13: assert (!valid_o && result_o == '0)
        else $error("reset state violated");
    end
  end
endmodule

bind fp_add_pipe fp_add_pipe_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/fp_add_pipe_tb.sv
`timescale 1ns/1ps
module fp_add_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fp_add_pipe u_dut (
    .clk_i(clk), .rst_ni, .valid_i, .op_i, .a_i, .b_i, .valid_o, .result_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // issue one op, sample four edges later
  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic op,
                       output logic [31:0] r, output logic v);
    @(negedge clk);
    a_i = a; b_i = b; op_i = op; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r = result_o;
    v = valid_o;
  endtask

  task automatic t_op(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic op, input logic [31:0] exp);
    logic [31:0] r;
    logic v;
    do_op(a, b, op, r, v);
    chk({req, " valid"}, {31'd0, v}, 32'd1);
    chk(req, r, exp);
  endtask

  task automatic test_reset();
    chk("R13 valid_o", {31'd0, valid_o}, 32'd0);
    chk("R13 result_o", result_o, 32'd0);
  endtask

  task automatic test_basic();
    t_op("R1 1+2", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000);
    t_op("R2 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000);
    t_op("R2 1-2", 32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000);
    t_op("R2 1-(-2)", 32'h3F800000, 32'hC0000000, 1'b1, 32'h40400000);
  endtask

  task automatic test_align();
    t_op("R3 1+minsub", 32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000);
    t_op("R3 1.5+0.25", 32'h3FC00000, 32'h3E800000, 1'b0, 32'h3FE00000);
  endtask

  task automatic test_cancel();
    t_op("R4 0.5-0.4375", 32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000);
    t_op("R4 ulp diff", 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000);
  endtask

  task automatic test_round();
    t_op("R5 tie even", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000);
    t_op("R5 tie odd", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002);
    t_op("R5 above half", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001);
    t_op("R6 carry renorm", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000);
  endtask

  task automatic test_subnormal();
    t_op("R7 sub+sub", 32'h00000001, 32'h00000001, 1'b0, 32'h00000002);
    t_op("R7 sub to normal", 32'h00400000, 32'h00400000, 1'b0, 32'h00800000);
    t_op("R7 normal to sub", 32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF);
  endtask

  task automatic test_overflow();
    t_op("R8 pos ovf", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000);
    t_op("R8 neg ovf", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000);
  endtask

  task automatic test_zero();
    t_op("R9 x-x", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000);
    t_op("R9 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000);
    t_op("R9 +0+-0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000);
  endtask

  task automatic test_inf();
    t_op("R10 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000);
    t_op("R10 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000);
    t_op("R10 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000);
  endtask

  task automatic test_nan();
    t_op("R11 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000);
    t_op("R11 nan in", 32'h7FA00000, 32'h3F800000, 1'b0, 32'h7FC00000);
    t_op("R11 nan b", 32'h3F800000, 32'hFFC00001, 1'b0, 32'h7FC00000);
  endtask

  task automatic test_pipeline();
    logic [31:0] va [6] = '{32'h3F800000, 32'h40400000, 32'h3F000000,
                            32'h7F800000, 32'h00000001, 32'h3F800000};
    logic [31:0] vb [6] = '{32'h40000000, 32'h3F800000, 32'hBEE00000,
                            32'h3F800000, 32'h00000001, 32'h40000000};
    logic        vo [6] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    logic [31:0] ve [6] = '{32'h40400000, 32'h40000000, 32'h3D800000,
                            32'h7F800000, 32'h00000002, 32'hBF800000};
    repeat (6) @(negedge clk);
    for (int j = 0; j < 11; j++) begin
      @(negedge clk);
      if (j < 4) chk("R12 empty", {31'd0, valid_o}, 32'd0);
      else if (j < 10) begin
        chk("R12 valid", {31'd0, valid_o}, 32'd1);
        chk("R12 order", result_o, ve[j-4]);
      end else chk("R12 drained", {31'd0, valid_o}, 32'd0);
      if (j < 6) begin
        a_i = va[j]; b_i = vb[j]; op_i = vo[j]; valid_i = 1'b1;
      end else valid_i = 1'b0;
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    test_basic();
    test_align();
    test_cancel();
    test_round();
    test_subnormal();
    test_overflow();
    test_zero();
    test_inf();
    test_nan();
    test_pipeline();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule